// File: doc/BRIEF.md
# I2S Stereo Audio Transceiver

This block is a bus-master I2S port that carries one stereo stream out and one stereo stream in. It produces the bit clock and the word-select line from the system clock through a programmable divider. Output samples come from a four-entry stereo queue and are shifted onto the serial data line. Serial input bits are gathered into stereo frames and placed into a second four-entry queue. Each queue entry holds a 24-bit left sample and a 24-bit right sample.

Software or a DMA engine feeds the output queue through a push port and drains the input queue through a pop port. Level-based interrupt lines with a selectable threshold and DMA request lines show when either queue needs service. Four settings change the wire format: sample resolution (16 or 24 bits), bit order (MSB or LSB first), bit-clock polarity and the divider. An output-queue underrun and an input-queue overrun each set a sticky flag.

Top module: `i2s_xcvr`

## Requirements
- R1: After reset the output queue is empty, the input queue is empty, both sticky flags are clear, and word select and serial data are low. While `enable` is low, `i2s_bclk` rests at the value of `cfg_bclk_inv`.
- R2: While enabled, each half period of the nominal bit clock lasts `cfg_div`+1 clock cycles. A frame is 64 bit clocks: word select is low for 32 (left) and high for 32 (right). Word select changes only on a nominal falling edge.
- R3: Serial output changes only on nominal falling edges. The first data bit of a slot appears one bit clock after the word-select change that opens the slot. With `cfg_res24`=1 and `cfg_lsb_first`=0, sample bits 23..0 are sent in that order and the remaining 8 bits of the 32-bit slot are zero.
- R4: With `cfg_res24`=0, only bits 15..0 of each pushed sample are sent, in the first 16 bit clocks of the slot. The other 16 are zero.
- R5: With `cfg_lsb_first`=1, the sample is sent starting from bit 0 and ending at its top bit (15 or 23).
- R6: With `cfg_bclk_inv`=1, the `i2s_bclk` pin is the inverse of the nominal bit clock. Data and word select then change on pin rising edges.
- R7: The input side samples `i2s_sdi` on nominal rising edges, using the same slot layout as the output side. It pushes one stereo entry per frame. Bits beyond the resolution are ignored. In 16-bit mode, bits 23..16 of the popped samples read zero.
- R8: The output queue holds four entries in order. `tx_full` is high at four. A push while full is dropped.
- R9: A slot start that finds the output queue empty sends an all-zero frame and sets `tx_underrun`, which stays high until reset.
- R10: A finished input frame that finds the input queue full is discarded. The older entries are kept, and `rx_overrun` is set and stays high until reset.
- R11: `tx_irq` follows the output-queue fill level `n` according to `cfg_tx_thr`: 0 means n==0, 1 means n<=2, 2 means n<4, and 3 keeps it low.
- R12: `rx_irq` follows the input-queue fill level according to `cfg_rx_thr`: 0 means the queue is full, 1 means it holds at least one entry.
- R13: `tx_dma_req` is high whenever the output queue has a free slot. `rx_dma_req` is high whenever the input queue is not empty.
- R14: A pop while the input queue is empty is ignored and leaves the queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the bit clock and both serial paths |
| cfg_div | input | DIV_W | Half-period of the bit clock, minus one, in clock cycles |
| cfg_res24 | input | 1 | 1: 24-bit samples, 0: 16-bit samples |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_bclk_inv | input | 1 | Inverts the bit clock pin |
| cfg_tx_thr | input | 2 | Output-queue interrupt threshold select |
| cfg_rx_thr | input | 1 | Input-queue interrupt threshold select |
| tx_push | input | 1 | Writes one stereo entry into the output queue |
| tx_left | input | 24 | Left sample to push |
| tx_right | input | 24 | Right sample to push |
| tx_full | output | 1 | Output queue full |
| tx_irq | output | 1 | Output-queue level interrupt |
| tx_dma_req | output | 1 | Output-queue DMA request |
| tx_underrun | output | 1 | Sticky output underrun flag |
| rx_pop | input | 1 | Removes the head entry of the input queue |
| rx_left | output | 24 | Left sample at the input-queue head |
| rx_right | output | 24 | Right sample at the input-queue head |
| rx_empty | output | 1 | Input queue empty |
| rx_irq | output | 1 | Input-queue level interrupt |
| rx_dma_req | output | 1 | Input-queue DMA request |
| rx_overrun | output | 1 | Sticky input overrun flag |
| i2s_bclk | output | 1 | Serial bit clock |
| i2s_ws | output | 1 | Word select, low for left |
| i2s_sdo | output | 1 | Serial data out |
| i2s_sdi | input | 1 | Serial data in |

## Verification
The serial output is decoded by an independent wire-level monitor and checked under four format combinations. These are 24-bit MSB first, 16-bit MSB first, 24-bit LSB first, and 16-bit LSB first with an inverted clock, and each one catches a different error: a wrong bit order, wrong truncation, or sampling on the wrong edge. The input side is tested two ways. A loopback of the output pin shows that captured frames match pushed frames in both resolutions. A constant-high input shows that trailing slot bits are ignored and that the upper bits read zero in 16-bit mode. Queue-boundary stimulus covers pushing a fifth entry, running dry, overflowing the input queue with six frames, and stepping the output queue through every level under every threshold setting.

// File: rtl/i2s_pkg.sv
package i2s_pkg;

    localparam int SMP_W    = 24;
    localparam int RES_HI   = 24;
    localparam int RES_LO   = 16;
    localparam int SLOT_LEN = 32;
    localparam int SLOT_W   = $clog2(SLOT_LEN);
    localparam int POS_W    = SLOT_W + 1;
    localparam int IDX_W    = $clog2(SMP_W);

    typedef struct packed {
        logic [SMP_W-1:0] left;
        logic [SMP_W-1:0] right;
    } stereo_t;

    typedef enum logic [1:0] {
        TXT_EMPTY   = 2'd0,
        TXT_HALF    = 2'd1,
        TXT_ONEFREE = 2'd2,
        TXT_OFF     = 2'd3
    } tx_thr_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } bitsel_t;

    // Maps a position inside a slot to the sample bit carried there.
    function automatic bitsel_t map_bit(input logic [SLOT_W-1:0] slot_pos,
                                        input logic res24,
                                        input logic lsb_first);
        bitsel_t r;
        logic [SLOT_W-1:0] res;
        res   = res24 ? SLOT_W'(RES_HI) : SLOT_W'(RES_LO);
        r.hit = slot_pos < res;
        r.idx = lsb_first ? IDX_W'(slot_pos) : IDX_W'(res - SLOT_W'(1) - slot_pos);
        return r;
    endfunction

endpackage

// File: rtl/i2s_fifo.sv
module i2s_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic          do_push;
    logic          do_pop;

    assign full    = count == CW'(DEPTH);
    assign empty   = count == '0;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= wdata;
                wp      <= wp + AW'(1);
            end
            if (do_pop) begin
                rp <= rp + AW'(1);
            end
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen #(
    parameter int DIV_W = 8,
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             ph,
    output logic             drive_ev,
    output logic             sample_ev,
    output logic [POS_W-1:0] pos
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick      = en && (cnt == div);
    assign drive_ev  = tick && ph;
    assign sample_ev = tick && !ph;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            ph  <= 1'b0;
            pos <= '0;
        end else begin
            if (tick) begin
                cnt <= '0;
                ph  <= !ph;
            end else begin
                cnt <= cnt + DIV_W'(1);
            end
            if (drive_ev) begin
                pos <= pos + POS_W'(1);
            end
        end
    end

endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
    import i2s_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [POS_W-1:0] pos,
    input  logic             res24,
    input  logic             lsb_first,
    input  stereo_t          head,
    input  logic             head_empty,
    output logic             head_pop,
    output logic             sdo,
    output logic             underrun
);
    stereo_t          cur;
    logic [POS_W-1:0] q;
    bitsel_t          sel;
    logic [SMP_W-1:0] word;

    assign head_pop = load && !head_empty;
    assign q        = pos - POS_W'(1);
    assign sel      = map_bit(q[SLOT_W-1:0], res24, lsb_first);
    assign word     = q[POS_W-1] ? cur.right : cur.left;
    assign sdo      = en && sel.hit && word[sel.idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            underrun <= 1'b0;
        end else if (load) begin
            cur <= head_empty ? '0 : head;
            if (head_empty) begin
                underrun <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2s_rx.sv
module i2s_rx
    import i2s_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             frame_start,
    input  logic             sample_ev,
    input  logic [POS_W-1:0] pos,
    input  logic             sdi,
    input  logic             res24,
    input  logic             lsb_first,
    input  logic             q_full,
    output logic             q_push,
    output stereo_t          q_data,
    output logic             overrun
);
    stereo_t          acc;
    logic             primed;
    logic             frame_done;
    logic [POS_W-1:0] q;
    bitsel_t          sel;

    assign q          = pos - POS_W'(1);
    assign sel        = map_bit(q[SLOT_W-1:0], res24, lsb_first);
    assign frame_done = sample_ev && (pos == '0) && primed;
    assign q_push     = frame_done && !q_full;
    assign q_data     = acc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            acc    <= '0;
            primed <= 1'b0;
        end else begin
            if (frame_start) begin
                primed <= 1'b1;
            end
            if (frame_done) begin
                acc <= '0;
            end else if (sample_ev && sel.hit) begin
                if (q[POS_W-1]) begin
                    acc.right[sel.idx] <= sdi;
                end else begin
                    acc.left[sel.idx] <= sdi;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun <= 1'b0;
        end else if (frame_done && q_full) begin
            overrun <= 1'b1;
        end
    end

endmodule

// File: rtl/i2s_xcvr.sv
module i2s_xcvr
    import i2s_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_res24,
    input  logic             cfg_lsb_first,
    input  logic             cfg_bclk_inv,
    input  logic [1:0]       cfg_tx_thr,
    input  logic             cfg_rx_thr,
    input  logic             tx_push,
    input  logic [SMP_W-1:0] tx_left,
    input  logic [SMP_W-1:0] tx_right,
    output logic             tx_full,
    output logic             tx_irq,
    output logic             tx_dma_req,
    output logic             tx_underrun,
    input  logic             rx_pop,
    output logic [SMP_W-1:0] rx_left,
    output logic [SMP_W-1:0] rx_right,
    output logic             rx_empty,
    output logic             rx_irq,
    output logic             rx_dma_req,
    output logic             rx_overrun,
    output logic             i2s_bclk,
    output logic             i2s_ws,
    output logic             i2s_sdo,
    input  logic             i2s_sdi
);
    localparam int          CW       = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);
    localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);

    logic             ph;
    logic             drive_ev;
    logic             sample_ev;
    logic [POS_W-1:0] pos;
    logic             frame_start;

    stereo_t          tx_in;
    stereo_t          tx_head;
    logic             tx_pop;
    logic             tx_empty;
    logic [CW-1:0]    tx_cnt;

    stereo_t          rx_in;
    stereo_t          rx_head;
    logic             rx_push;
    logic             rx_full;
    logic [CW-1:0]    rx_cnt;

    i2s_clkgen #(.DIV_W(DIV_W), .POS_W(POS_W)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .en        (enable),
        .div       (cfg_div),
        .ph        (ph),
        .drive_ev  (drive_ev),
        .sample_ev (sample_ev),
        .pos       (pos)
    );

    assign frame_start = drive_ev && (pos == '0);
    assign i2s_bclk    = ph ^ cfg_bclk_inv;
    assign i2s_ws      = pos[POS_W-1];

    assign tx_in.left  = tx_left;
    assign tx_in.right = tx_right;

    i2s_fifo #(.W($bits(stereo_t)), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push),
        .wdata (tx_in),
        .pop   (tx_pop),
        .rdata (tx_head),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    i2s_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .en         (enable),
        .load       (frame_start),
        .pos        (pos),
        .res24      (cfg_res24),
        .lsb_first  (cfg_lsb_first),
        .head       (tx_head),
        .head_empty (tx_empty),
        .head_pop   (tx_pop),
        .sdo        (i2s_sdo),
        .underrun   (tx_underrun)
    );

    i2s_rx u_rx (
        .clk         (clk),
        .rst         (rst),
        .en          (enable),
        .frame_start (frame_start),
        .sample_ev   (sample_ev),
        .pos         (pos),
        .sdi         (i2s_sdi),
        .res24       (cfg_res24),
        .lsb_first   (cfg_lsb_first),
        .q_full      (rx_full),
        .q_push      (rx_push),
        .q_data      (rx_in),
        .overrun     (rx_overrun)
    );

    i2s_fifo #(.W($bits(stereo_t)), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .wdata (rx_in),
        .pop   (rx_pop),
        .rdata (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign rx_left  = rx_head.left;
    assign rx_right = rx_head.right;

    always_comb begin
        case (tx_thr_e'(cfg_tx_thr))
            TXT_EMPTY:   tx_irq = tx_cnt == '0;
            TXT_HALF:    tx_irq = tx_cnt <= LVL_HALF;
            TXT_ONEFREE: tx_irq = tx_cnt < LVL_FULL;
            default:     tx_irq = 1'b0;
        endcase
    end

    assign rx_irq     = cfg_rx_thr ? (rx_cnt != '0) : (rx_cnt == LVL_FULL);
    assign tx_dma_req = !tx_full;
    assign rx_dma_req = !rx_empty;

endmodule

// File: rtl/i2s_xcvr_chk.sv
module i2s_xcvr_chk (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic cfg_bclk_inv,
    input logic cfg_rx_thr,
    input logic i2s_bclk,
    input logic i2s_ws,
    input logic i2s_sdo,
    input logic tx_underrun,
    input logic rx_overrun,
    input logic rx_irq,
    input logic rx_empty
);
    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        (!enable && $past(!enable)) |-> (i2s_bclk == cfg_bclk_inv) && !i2s_ws && !i2s_sdo); // R1

    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && (i2s_ws != $past(i2s_ws))) |-> $fell(i2s_bclk ^ cfg_bclk_inv)); // R2

    AST_SDO_STILL_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && $rose(i2s_bclk ^ cfg_bclk_inv)) |-> $stable(i2s_sdo)); // R3

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        tx_underrun |=> tx_underrun); // R9

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |=> rx_overrun); // R10

    AST_RX_IRQ_ANY: assert property (@(posedge clk) disable iff (rst)
        cfg_rx_thr |-> (rx_irq == !rx_empty)); // R12

endmodule

bind i2s_xcvr i2s_xcvr_chk chk_i (.*);

// File: tb/i2s_xcvr_tb_top.sv
`timescale 1ns/1ps
module i2s_xcvr_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [7:0]  cfg_div;
    logic        cfg_res24, cfg_lsb_first, cfg_bclk_inv, cfg_rx_thr;
    logic [1:0]  cfg_tx_thr;
    logic        tx_push, rx_pop;
    logic [23:0] tx_left, tx_right, rx_left, rx_right;
    logic        tx_full, tx_irq, tx_dma_req, tx_underrun;
    logic        rx_empty, rx_irq, rx_dma_req, rx_overrun;
    logic        i2s_bclk, i2s_ws, i2s_sdo, i2s_sdi;
    logic        loop_en, ext_sdi;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign i2s_sdi = loop_en ? i2s_sdo : ext_sdi;

    i2s_xcvr dut_i (.*);

    // wire-level monitor
    logic        mon_on = 1'b0;
    int          mon_pos = -1;
    logic        mon_ws = 1'b0;
    logic [31:0] mon_slot = '0;
    logic [31:0] cap_l [16];
    logic [31:0] cap_r [16];
    int          cap_n = 0;

    always @(posedge i2s_bclk or negedge i2s_bclk) begin
        if (mon_on && ((i2s_bclk ^ cfg_bclk_inv) == 1'b1)) begin
            if (i2s_ws != mon_ws) begin
                if (mon_pos == 31) begin
                    mon_slot[0] = i2s_sdo;
                    if (mon_ws) begin
                        cap_r[cap_n % 16] = mon_slot;
                        cap_n++;
                    end else begin
                        cap_l[cap_n % 16] = mon_slot;
                    end
                end
                mon_ws  = i2s_ws;
                mon_pos = 0;
            end else if (mon_pos < 0) begin
                mon_pos = 0;
            end else if (mon_pos < 31) begin
                mon_slot[31 - mon_pos] = i2s_sdo;
                mon_pos++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] pat(input int i, input int ch);
        return 24'hA53C96 ^ 24'(i * 24'h1F3B7) ^ (ch != 0 ? 24'hF0F00F : 24'h0);
    endfunction

    function automatic logic [31:0] exp_slot(input logic [23:0] s, input logic r24, input logic lsb);
        logic [31:0] o;
        int res;
        o = '0;
        res = r24 ? 24 : 16;
        for (int t = 0; t < res; t++) o[31 - t] = lsb ? s[t] : s[res - 1 - t];
        return o;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; enable = 1'b0; cfg_div = 8'd1; cfg_res24 = 1'b1;
        cfg_lsb_first = 1'b0; cfg_bclk_inv = 1'b0; cfg_tx_thr = 2'd0; cfg_rx_thr = 1'b0;
        tx_push = 1'b0; rx_pop = 1'b0; tx_left = '0; tx_right = '0;
        loop_en = 1'b0; ext_sdi = 1'b0; mon_on = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic push(input int i);
        @(negedge clk);
        tx_push = 1'b1; tx_left = pat(i, 0); tx_right = pat(i, 1);
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop(output logic [23:0] l, output logic [23:0] r);
        @(negedge clk);
        l = rx_left; r = rx_right; rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic run_start(input int div, input logic r24, input logic lsb,
                             input logic inv, input logic lp);
        @(negedge clk);
        cfg_div = 8'(div); cfg_res24 = r24; cfg_lsb_first = lsb;
        cfg_bclk_inv = inv; loop_en = lp;
        cap_n = 0; mon_pos = -1; mon_ws = 1'b0; mon_slot = '0;
        @(negedge clk);
        mon_on = 1'b1; enable = 1'b1;
    endtask

    task automatic run_stop();
        @(negedge clk);
        enable = 1'b0; mon_on = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 bclk", 32'(i2s_bclk), 0);
        chk("R1 ws", 32'(i2s_ws), 0);
        chk("R1 sdo", 32'(i2s_sdo), 0);
        chk("R1 tx_full", 32'(tx_full), 0);
        chk("R1 rx_empty", 32'(rx_empty), 1);
        chk("R1 flags", {30'd0, tx_underrun, rx_overrun}, 0);
        chk("R11 empty irq", 32'(tx_irq), 1);
        chk("R12 full irq", 32'(rx_irq), 0);
        chk("R13 dma", {30'd0, tx_dma_req, rx_dma_req}, 32'd2);
    endtask

    task automatic t_clock();
        int a, b, c, d, e;
        do_reset();
        run_start(2, 1'b1, 1'b0, 1'b0, 1'b0);
        @(posedge i2s_ws); @(negedge clk); a = cyc;
        chk("R2 ws rise on bclk fall", 32'(i2s_bclk), 0);
        @(negedge i2s_ws); @(negedge clk); b = cyc;
        chk("R2 ws fall on bclk fall", 32'(i2s_bclk), 0);
        @(posedge i2s_ws); @(negedge clk); c = cyc;
        @(posedge i2s_bclk); @(negedge clk); d = cyc;
        @(posedge i2s_bclk); @(negedge clk); e = cyc;
        run_stop();
        chk("R2 right slot length", 32'(b - a), 32'd192);
        chk("R2 left slot length", 32'(c - b), 32'd192);
        chk("R2 bclk period", 32'(e - d), 32'd6);
    endtask

    task automatic t_tx_mode(input logic r24, input logic lsb, input logic inv, input string tag);
        do_reset();
        for (int i = 0; i < 3; i++) push(i + 8);
        run_start(1, r24, lsb, inv, 1'b0);
        while (cap_n < 3) @(negedge clk);
        run_stop();
        for (int i = 0; i < 3; i++) begin
            chk(tag, cap_l[i], exp_slot(pat(i + 8, 0), r24, lsb));
            chk(tag, cap_r[i], exp_slot(pat(i + 8, 1), r24, lsb));
        end
        chk({tag, " idle bclk"}, 32'(i2s_bclk), 32'(inv));
    endtask

    task automatic t_full_underrun();
        do_reset();
        for (int i = 0; i < 4; i++) push(i);
        chk("R8 full at four", 32'(tx_full), 1);
        chk("R13 no tx dma when full", 32'(tx_dma_req), 0);
        push(9);
        chk("R9 no underrun yet", 32'(tx_underrun), 0);
        run_start(1, 1'b1, 1'b0, 1'b0, 1'b0);
        while (cap_n < 5) @(negedge clk);
        run_stop();
        for (int i = 0; i < 4; i++) begin
            chk("R8 order", cap_l[i], exp_slot(pat(i, 0), 1'b1, 1'b0));
            chk("R8 order", cap_r[i], exp_slot(pat(i, 1), 1'b1, 1'b0));
        end
        chk("R8 fifth dropped / R9 zero left", cap_l[4], 0);
        chk("R9 zero right", cap_r[4], 0);
        chk("R9 underrun flag", 32'(tx_underrun), 1);
    endtask

    task automatic t_rx_loop(input logic r24, input logic lsb);
        logic [23:0] l, r, m;
        do_reset();
        m = r24 ? 24'hFFFFFF : 24'h00FFFF;
        for (int i = 0; i < 3; i++) push(i + 20);
        run_start(1, r24, lsb, 1'b0, 1'b1);
        while (cap_n < 3) @(negedge clk);
        repeat (4) @(negedge clk);
        run_stop();
        for (int i = 0; i < 3; i++) begin
            pop(l, r);
            chk("R7 loop left", 32'(l), 32'(pat(i + 20, 0) & m));
            chk("R7 loop right", 32'(r), 32'(pat(i + 20, 1) & m));
        end
        chk("R7 three frames only", 32'(rx_empty), 1);
    endtask

    task automatic t_rx_ones(input logic r24);
        logic [23:0] l, r;
        do_reset();
        ext_sdi = 1'b1;
        run_start(1, r24, 1'b0, 1'b0, 1'b0);
        while (rx_empty) @(negedge clk);
        run_stop();
        pop(l, r);
        chk("R7 ones left", 32'(l), r24 ? 32'hFFFFFF : 32'h00FFFF);
        chk("R7 ones right", 32'(r), r24 ? 32'hFFFFFF : 32'h00FFFF);
    endtask

    task automatic t_overrun();
        logic [23:0] l, r;
        do_reset();
        for (int i = 0; i < 4; i++) push(i + 40);
        run_start(1, 1'b1, 1'b0, 1'b0, 1'b1);
        for (int i = 4; i < 6; i++) begin
            while (tx_full) @(negedge clk);
            push(i + 40);
        end
        while (cap_n < 6) @(negedge clk);
        repeat (8) @(negedge clk);
        run_stop();
        chk("R10 overrun flag", 32'(rx_overrun), 1);
        chk("R12 full irq", 32'(rx_irq), 1);
        chk("R13 rx dma", 32'(rx_dma_req), 1);
        cfg_rx_thr = 1'b1;
        for (int i = 0; i < 4; i++) begin
            pop(l, r);
            chk("R10 oldest kept left", 32'(l), 32'(pat(i + 40, 0)));
            chk("R10 oldest kept right", 32'(r), 32'(pat(i + 40, 1)));
            chk("R12 any irq", 32'(rx_irq), 32'(i < 3));
        end
        chk("R13 rx dma idle", 32'(rx_dma_req), 0);
        pop(l, r);
        chk("R14 empty pop ignored", 32'(rx_empty), 1);
        chk("R14 irq stays low", 32'(rx_irq), 0);
        chk("R10 flag held", 32'(rx_overrun), 1);
    endtask

    task automatic t_irq_levels();
        logic exp;
        do_reset();
        for (int n = 0; n <= 4; n++) begin
            for (int t = 0; t < 4; t++) begin
                @(negedge clk);
                cfg_tx_thr = 2'(t);
                #1;
                case (t)
                    0: exp = (n == 0);
                    1: exp = (n <= 2);
                    2: exp = (n < 4);
                    default: exp = 1'b0;
                endcase
                chk("R11 tx irq level", 32'(tx_irq), 32'(exp));
            end
            chk("R13 tx dma level", 32'(tx_dma_req), 32'(n < 4));
            if (n < 4) push(n);
        end
    endtask

    initial begin
        t_reset();
        t_clock();
        t_tx_mode(1'b1, 1'b0, 1'b0, "R3 24 msb");
        t_tx_mode(1'b0, 1'b0, 1'b0, "R4 16 msb");
        t_tx_mode(1'b1, 1'b1, 1'b0, "R5 24 lsb");
        t_tx_mode(1'b0, 1'b1, 1'b1, "R6 16 lsb inverted");
        t_full_underrun();
        t_rx_loop(1'b1, 1'b0);
        t_rx_loop(1'b0, 1'b1);
        t_rx_ones(1'b0);
        t_rx_ones(1'b1);
        t_overrun();
        t_irq_levels();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule